// File: doc/BRIEF.md
# Multiply/Accumulate Issue Interlock

This block decides each cycle whether the instruction at the head of an in-order issue stage may go or must wait. It sits beside a multiply/accumulate unit whose operations take a variable number of cycles. The unit's result lands in a fixed destination register or register pair. Ordinary instructions keep flowing while a MAC operation is in flight. Only three things hold the head instruction back:
- a read of the result before it is ready;
- a second multiplier operation presented too soon after the previous one;
- any MAC operation presented while a long serialising operation (a complex sum or FFT step) is still running.

The issue stage supplies a descriptor every cycle: a valid bit, four flags and the latency granted to a MAC operation. The block answers with one stall bit. An instruction issues on a rising edge where it is valid and not stalled. Three down-counters hold the timing state: result readiness, multiplier spacing and serialisation. Each counter is loaded when a MAC operation issues and counts down to zero. The stall bit is the OR of the three hold conditions.

Top module: `mac_issue_interlock`

## Requirements
- R1: After reset all hold conditions are clear, so a valid instruction with any flags issues in the first cycle after reset.
- R2: A valid instruction that is neither a MAC operation nor a reader of the result never stalls, whatever MAC work is outstanding.
- R3: After a non-serialising MAC operation with granted latency L issues in cycle t, an instruction that reads the result stalls until cycle t+L+1. It issues without stall from that cycle on, and immediately if L is 0.
- R4: Cycles spent on other instructions or idle after a MAC issue count toward its latency. A reader presented k cycles after the MAC issue waits max(0, L-k) cycles.
- R5: After a multiplier-using MAC operation with latency L issues in cycle t, another multiplier-using MAC operation cannot issue before cycle t+L. There is no spacing when L is 0 or 1.
- R6: A MAC operation that does not use the multiplier is not held by the multiplier spacing rule.
- R7: After a serialising operation issues in cycle t, every MAC operation stalls until cycle t+SER_LAT+1. Its result also becomes available in cycle t+SER_LAT+1, so a reader follows the R3 timing with latency SER_LAT.
- R8: When several hold conditions apply at once, the stall lasts until the last of them clears. The stall is low whenever the valid input is low.
- R9: Each MAC issue restarts the result timing with its own latency, replacing whatever remained of the previous operation's latency.
- R10: A stalled instruction does not issue. Spacing and readiness are measured from the cycle in which an operation actually issues, not from the cycles in which it was presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A descriptor is presented this cycle |
| in_is_mac | input | 1 | Instruction executes in the MAC unit |
| in_uses_mult | input | 1 | MAC instruction occupies the hardware multiplier |
| in_is_serial | input | 1 | MAC instruction is a long serialising operation |
| in_reads_result | input | 1 | Instruction reads the MAC result register or pair |
| in_latency | input | LAT_W | Latency granted to this MAC operation (ignored for serialising ones) |
| stall | output | 1 | Head instruction must wait this cycle |

## Verification
The hardest case to reach is two hold reasons overlapping with different end cycles. An example is a multiplier operation that also reads the result, presented right after a multiplier issue: the spacing rule clears one cycle before readiness does. A related hard case is a stalled operation that must not restart any counter. The bench reaches both by issuing chosen latencies back to back from a task that keeps the descriptor valid and counts the stalled cycles. It also mixes in plain instructions and idle cycles to show that hidden latency is credited. Every wait count is compared against a closed-form figure derived from the issue cycle and the latency.

// File: rtl/mac_il_pkg.sv
package mac_il_pkg;

  // Spacing required between two multiplier operations: one less than the
  // latency of the first, never negative.
  function automatic int mult_gap(input int lat);
    return (lat > 0) ? lat - 1 : 0;
  endfunction

  // Wider of two widths, used to size the shared counters.
  function automatic int max_w(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/il_countdown.sv
module il_countdown #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (cnt == $past(cnt) - 1'b1));

  // R9
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/il_stall_merge.sv
module il_stall_merge (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_is_mac,
  input  logic in_uses_mult,
  input  logic in_reads_result,
  input  logic res_busy,
  input  logic mult_busy,
  input  logic ser_busy,
  output logic hold_result,
  output logic hold_mult,
  output logic hold_serial,
  output logic stall
);

  assign hold_result = in_valid && in_reads_result && res_busy;
  assign hold_mult   = in_valid && in_is_mac && in_uses_mult && mult_busy;
  assign hold_serial = in_valid && in_is_mac && ser_busy;
  assign stall       = hold_result || hold_mult || hold_serial;

  // R2
  plain_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_is_mac && !in_reads_result) |-> !stall);

  // R8
  idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !stall);

endmodule

// File: rtl/mac_issue_interlock.sv
module mac_issue_interlock
  import mac_il_pkg::*;
#(
  parameter int LAT_W   = 4,
  parameter int SER_LAT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_is_mac,
  input  logic             in_uses_mult,
  input  logic             in_is_serial,
  input  logic             in_reads_result,
  input  logic [LAT_W-1:0] in_latency,
  output logic             stall
);

  localparam int SER_W = $clog2(SER_LAT + 1);
  localparam int CNT_W = max_w(LAT_W, SER_W);
  localparam logic [CNT_W-1:0] SER_VAL  = CNT_W'(SER_LAT);
  localparam logic [CNT_W-1:0] SER_GAP  = CNT_W'(mult_gap(SER_LAT));

  // Named internal events
  logic             mac_issue;
  logic             mult_issue;
  logic             ser_issue;
  logic [CNT_W-1:0] res_val;
  logic [CNT_W-1:0] mult_val;
  logic             res_busy, mult_busy, ser_busy;
  logic             hold_result, hold_mult, hold_serial;

  assign mac_issue  = in_valid && in_is_mac && !stall;
  assign mult_issue = mac_issue && in_uses_mult;
  assign ser_issue  = mac_issue && in_is_serial;

  assign res_val  = in_is_serial ? SER_VAL : CNT_W'(in_latency);
  assign mult_val = in_is_serial ? SER_GAP
                                 : CNT_W'(mult_gap(int'(in_latency)));

  il_countdown #(.W(CNT_W)) u_res_cnt (
    .clk(clk), .rst_n(rst_n), .load(mac_issue), .load_val(res_val),
    .busy(res_busy));

  il_countdown #(.W(CNT_W)) u_mult_cnt (
    .clk(clk), .rst_n(rst_n), .load(mult_issue), .load_val(mult_val),
    .busy(mult_busy));

  il_countdown #(.W(CNT_W)) u_ser_cnt (
    .clk(clk), .rst_n(rst_n), .load(ser_issue), .load_val(SER_VAL),
    .busy(ser_busy));

  il_stall_merge u_merge (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_is_mac(in_is_mac), .in_uses_mult(in_uses_mult),
    .in_reads_result(in_reads_result),
    .res_busy(res_busy), .mult_busy(mult_busy), .ser_busy(ser_busy),
    .hold_result(hold_result), .hold_mult(hold_mult),
    .hold_serial(hold_serial), .stall(stall));

  // R3
  result_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_issue && !in_is_serial && in_latency != '0) ##1
    (in_valid && in_reads_result) |-> stall);

  // R5
  mult_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mult_issue && !in_is_serial && in_latency >= 2) ##1
    (in_valid && in_is_mac && in_uses_mult) |-> stall);

  // R7
  serial_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_issue ##1 (in_valid && in_is_mac) |-> stall);

  // R10
  no_issue_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_is_mac && stall) |-> !mac_issue);

endmodule

// File: tb/mac_issue_interlock_bench.sv
module mac_issue_interlock_bench;

  localparam int LAT_W   = 4;
  localparam int SER_LAT = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_is_mac = 1'b0;
  logic             in_uses_mult = 1'b0;
  logic             in_is_serial = 1'b0;
  logic             in_reads_result = 1'b0;
  logic [LAT_W-1:0] in_latency = '0;
  logic             stall;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  mac_issue_interlock #(.LAT_W(LAT_W), .SER_LAT(SER_LAT)) u_mac_issue_interlock (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_mac(in_is_mac),
    .in_uses_mult(in_uses_mult), .in_is_serial(in_is_serial),
    .in_reads_result(in_reads_result), .in_latency(in_latency), .stall(stall));

  function automatic int sat0(input int v);
    return (v > 0) ? v : 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Present one instruction, keep it valid until it issues; report stalled cycles.
  task automatic present(input bit mac, input bit mult, input bit ser, input bit rd,
                         input int lat, output int waits);
    waits = 0;
    @(negedge clk);
    in_valid = 1'b1; in_is_mac = mac; in_uses_mult = mult;
    in_is_serial = ser; in_reads_result = rd; in_latency = LAT_W'(lat);
    #1;
    while (stall && waits < 100) begin
      @(negedge clk); #1;
      waits++;
    end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_is_mac = 1'b0; in_reads_result = 1'b0;
      in_uses_mult = 1'b0; in_is_serial = 1'b0;
      @(posedge clk);
    end
  endtask

  task automatic expect_wait(input bit mac, input bit mult, input bit ser, input bit rd,
                             input int lat, input int exp, input string req);
    int w;
    present(mac, mult, ser, rd, lat, w);
    check(w == exp, req, w, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    in_valid = 1'b1; in_is_mac = 1'b1; in_uses_mult = 1'b1; in_is_serial = 1'b0;
    in_reads_result = 1'b1; in_latency = '0;
    #1;
    check(stall == 1'b0, "R1", stall, 0);
    idle(1);
  endtask

  task automatic t_plain;
    expect_wait(1, 1, 0, 0, 9, 0, "R2");
    expect_wait(0, 0, 0, 0, 0, 0, "R2");
    expect_wait(0, 0, 0, 0, 0, 0, "R2");
    idle(20);
  endtask

  task automatic t_result;
    expect_wait(1, 0, 0, 0, 3, 0, "R3");
    expect_wait(0, 0, 0, 1, 0, 3, "R3");
    expect_wait(1, 0, 0, 0, 0, 0, "R3");
    expect_wait(0, 0, 0, 1, 0, 0, "R3");
    idle(20);
  endtask

  task automatic t_hide;
    expect_wait(1, 1, 0, 0, 4, 0, "R4");
    expect_wait(0, 0, 0, 0, 0, 0, "R4");
    idle(1);
    expect_wait(0, 0, 0, 1, 0, sat0(4 - 2), "R4");
    idle(20);
    expect_wait(1, 1, 0, 0, 2, 0, "R4");
    idle(3);
    expect_wait(0, 0, 0, 1, 0, sat0(2 - 3), "R4");
    idle(20);
  endtask

  task automatic t_mult;
    expect_wait(1, 1, 0, 0, 4, 0, "R5");
    expect_wait(1, 1, 0, 0, 1, 4 - 1, "R5");
    expect_wait(1, 1, 0, 0, 1, 0, "R5");
    idle(20);
    expect_wait(1, 1, 0, 0, 5, 0, "R5");
    idle(2);
    expect_wait(1, 1, 0, 0, 0, sat0(5 - 1 - 2), "R5");
    idle(20);
  endtask

  task automatic t_nomult;
    expect_wait(1, 1, 0, 0, 6, 0, "R6");
    expect_wait(1, 0, 0, 0, 2, 0, "R6");
    idle(20);
  endtask

  task automatic t_serial;
    expect_wait(1, 0, 1, 0, 0, 0, "R7");
    expect_wait(1, 0, 0, 0, 1, SER_LAT, "R7");
    idle(20);
    expect_wait(1, 1, 1, 0, 0, 0, "R7");
    expect_wait(0, 0, 0, 0, 0, 0, "R7");
    expect_wait(0, 0, 0, 0, 0, 0, "R7");
    expect_wait(0, 0, 0, 0, 0, 0, "R7");
    expect_wait(0, 0, 0, 1, 0, SER_LAT - 3, "R7");
    idle(20);
  endtask

  task automatic t_or;
    expect_wait(1, 1, 0, 0, 3, 0, "R8");
    expect_wait(1, 1, 0, 1, 1, 3, "R8");
    idle(20);
    expect_wait(1, 0, 0, 0, 9, 0, "R8");
    @(negedge clk);
    in_valid = 1'b0; in_is_mac = 1'b1; in_uses_mult = 1'b1; in_reads_result = 1'b1;
    #1;
    check(stall == 1'b0, "R8", stall, 0);
    idle(20);
  endtask

  task automatic t_reload;
    expect_wait(1, 0, 0, 0, 7, 0, "R9");
    expect_wait(1, 0, 0, 0, 1, 0, "R9");
    expect_wait(0, 0, 0, 1, 0, 1, "R9");
    idle(20);
  endtask

  task automatic t_stalled;
    expect_wait(1, 1, 0, 0, 4, 0, "R10");
    expect_wait(1, 1, 0, 0, 9, 3, "R10");
    expect_wait(1, 1, 0, 0, 2, 9 - 1, "R10");
    idle(20);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_plain;
    t_result;
    t_hide;
    t_mult;
    t_nomult;
    t_serial;
    t_or;
    t_reload;
    t_stalled;
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule